// File: doc/BRIEF.md
# Program Trace Compressor

This block sits behind a processor's instruction-status pins during a trace capture window and turns the per-clock report stream into a compact sequence of flow-change records. Each clock it takes a 3-bit status code and a 2-bit cancel code, which together make five bits per clock. A show-cycle strobe carries a 30-bit target address when an indirect branch becomes visible. Sequential instructions are never stored. They are counted. A record is written only when a branch or indirect flow change retires from the cancel window, and that record carries the number of sequential instructions that retired since the previous record.

Reported instructions first wait in a short pending window, so that a later cancel code can still withdraw them. When the window closes, the pending entries drain one per clock and a final record carries the residual count. Records leave through a valid/ready interface backed by a small FIFO. If the FIFO is full, a new record is dropped and a sticky error flag is raised. The trace source cannot be stalled, so the block does not apply backpressure to it.

Top module: `trc_compress`

## Requirements
- R1: After reset, `rec_valid_o` and `ovf_err_o` are low.
- R2: While `cap_i` is high, status code 1 reports a sequential instruction. It produces no record of its own and adds one to the run count when it retires. Codes 0, 5, 6 and 7 report nothing.
- R3: When a direct branch retires, it emits a record with type 0 (status code 2, taken) or type 1 (status code 3, not taken). The record carries the run count accumulated since the previous record, and the run count then restarts at zero.
- R4: When an indirect flow change retires (status code 4), it emits a record with type 2. A show strobe attaches its address to the newest pending entry, after that clock's cancel, push and retire, only if that entry is an indirect flow change. Otherwise the address is dropped. An indirect record with no attached address carries address 0.
- R5: While `cap_i` is high, cancel code k withdraws the newest min(k, pending) entries before the same clock's status is entered. Withdrawn entries are never counted and never recorded.
- R6: Up to 3 entries are held pending. The oldest entry retires on the clock when a new entry would make 4. At most one entry retires per clock, and its record is visible on the output the clock after.
- R7: When a retiring sequential instruction brings the run count to 65535, it emits a type 3 record with count 65535 and `rec_last_o` low, and the run count restarts at zero.
- R8: After `cap_i` falls, the pending entries retire one per clock, oldest first. Once none remain, exactly one type 3 record is emitted with `rec_last_o` high and the residual run count, and the count is then cleared.
- R9: Records are presented in order. The FIFO holds up to 4 records. While `rec_ready_i` is low, the presented record stays unchanged.
- R10: A record that arrives while the FIFO holds 4 records and none is leaving is dropped. `ovf_err_o` then goes high and stays high until reset.
- R11: While `cap_i` is low, the status, cancel and show inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_i | input | 1 | Capture window active |
| st_i | input | 3 | Instruction status code for this clock |
| fl_i | input | 2 | Number of newest pending instructions to cancel |
| show_vld_i | input | 1 | Show-cycle address present |
| show_addr_i | input | 30 | Show-cycle target address |
| rec_valid_o | output | 1 | Record available |
| rec_ready_i | input | 1 | Downstream accepts the record |
| rec_type_o | output | 2 | 0 direct taken, 1 direct not taken, 2 indirect, 3 run-only |
| rec_cnt_o | output | 16 | Sequential instructions since the previous record |
| rec_addr_o | output | 30 | Indirect target address, otherwise 0 |
| rec_last_o | output | 1 | Final record of a capture window |
| ovf_err_o | output | 1 | Sticky record-drop flag |

## Verification
The hardest case to reach from the ports is the run-count overflow. It needs 65535 sequential instructions to retire with no flow change and no cancel. The stimulus reaches it with one long burst of sequential codes and then closes the window, so the residual count also lands in the final record. The FIFO drop is the other rare case. The stimulus holds ready low while mixing branches with runs of different lengths, so that the four stored records stay distinguishable after the drain, and then adds one more retiring branch.

// File: rtl/trc_pkg.sv
package trc_pkg;
   // input status codes
   localparam logic [2:0] ST_SEQ = 3'd1;
   localparam logic [2:0] ST_DTK = 3'd2;
   localparam logic [2:0] ST_DNT = 3'd3;
   localparam logic [2:0] ST_IND = 3'd4;

   // record types; branch kinds share their numeric code with the record type
   typedef enum logic [1:0] {
      RT_DTK = 2'd0,
      RT_DNT = 2'd1,
      RT_IND = 2'd2,
      RT_RUN = 2'd3
   } rec_t;

   typedef enum logic [1:0] {
      K_DTK = 2'd0,
      K_DNT = 2'd1,
      K_IND = 2'd2,
      K_SEQ = 2'd3
   } kind_t;
endpackage

// File: rtl/trc_hist.sv
module trc_hist
   import trc_pkg::*;
#(
   parameter int HIST_D = 3,
   parameter int FL_W   = 2,
   parameter int ADDR_W = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [2:0]        st_i,
   input  logic [FL_W-1:0]   fl_i,
   input  logic              show_vld_i,
   input  logic [ADDR_W-1:0] show_addr_i,
   output logic              cmt_vld_o,
   output kind_t             cmt_kind_o,
   output logic [ADDR_W-1:0] cmt_addr_o,
   output logic              empty_o
);
   localparam int OCC_W = $clog2(HIST_D + 2);
   localparam int IW    = $clog2(HIST_D + 1);

   kind_t             kind_q [HIST_D];
   logic [ADDR_W-1:0] addr_q [HIST_D];
   logic [OCC_W-1:0]  occ_q, occ_d;

   kind_t             kind_n [HIST_D+1];
   logic [ADDR_W-1:0] addr_n [HIST_D+1];
   logic              push, shift;
   kind_t             new_kind;
   int                o;

   always_comb begin
      push     = 1'b1;
      new_kind = K_SEQ;
      case (st_i)
         ST_SEQ:  new_kind = K_SEQ;
         ST_DTK:  new_kind = K_DTK;
         ST_DNT:  new_kind = K_DNT;
         ST_IND:  new_kind = K_IND;
         default: push = 1'b0;
      endcase
   end

   always_comb begin
      for (int i = 0; i < HIST_D; i++) begin
         kind_n[i] = kind_q[i];
         addr_n[i] = addr_q[i];
      end
      kind_n[HIST_D] = K_SEQ;
      addr_n[HIST_D] = '0;
      o          = int'(occ_q);
      shift      = 1'b0;
      cmt_kind_o = K_SEQ;
      cmt_addr_o = '0;
      if (cap_i) begin
         if (int'(fl_i) >= o) o = 0;
         else                 o = o - int'(fl_i);
         if (push) begin
            kind_n[IW'(o)] = new_kind;
            addr_n[IW'(o)] = '0;
            o = o + 1;
         end
         if (o == HIST_D + 1) shift = 1'b1;
      end else if (o != 0) begin
         shift = 1'b1;
      end
      if (shift) begin
         cmt_kind_o = kind_n[0];
         cmt_addr_o = addr_n[0];
         for (int i = 0; i < HIST_D; i++) begin
            kind_n[i] = kind_n[i+1];
            addr_n[i] = addr_n[i+1];
         end
         o = o - 1;
      end
      if (cap_i && show_vld_i && o != 0) begin
         if (kind_n[IW'(o-1)] == K_IND) addr_n[IW'(o-1)] = show_addr_i;
      end
      occ_d = OCC_W'(o);
   end

   assign cmt_vld_o = shift;
   assign empty_o   = (occ_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_q <= '0;
         for (int i = 0; i < HIST_D; i++) begin
            kind_q[i] <= K_SEQ;
            addr_q[i] <= '0;
         end
      end else begin
         occ_q <= occ_d;
         for (int i = 0; i < HIST_D; i++) begin
            kind_q[i] <= kind_n[i];
            addr_q[i] <= addr_n[i];
         end
      end
   end

   AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= OCC_W'(HIST_D)); // R6
   AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_i && occ_q != '0) |=> (occ_q == $past(occ_q) - 1'b1)); // R8
   AST_FULL_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_i && int'(fl_i) >= int'(occ_q) && !push) |=> (occ_q == '0)); // R5
endmodule

// File: rtl/trc_runcnt.sv
module trc_runcnt
   import trc_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic              cmt_vld_i,
   input  kind_t             cmt_kind_i,
   input  logic [ADDR_W-1:0] cmt_addr_i,
   input  logic              hist_empty_i,
   output logic              rec_vld_o,
   output rec_t              rec_type_o,
   output logic [CNT_W-1:0]  rec_cnt_o,
   output logic [ADDR_W-1:0] rec_addr_o,
   output logic              rec_last_o
);
   localparam logic [CNT_W-1:0] CNT_LAST = {{(CNT_W-1){1'b1}}, 1'b0};

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             armed_q, armed_d;

   always_comb begin
      rec_vld_o  = 1'b0;
      rec_type_o = RT_RUN;
      rec_cnt_o  = cnt_q;
      rec_addr_o = '0;
      rec_last_o = 1'b0;
      cnt_d      = cnt_q;
      armed_d    = armed_q | cap_i;
      if (cmt_vld_i) begin
         if (cmt_kind_i == K_SEQ) begin
            if (cnt_q == CNT_LAST) begin
               rec_vld_o = 1'b1;
               rec_cnt_o = '1;
               cnt_d     = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end else begin
            rec_vld_o  = 1'b1;
            rec_type_o = rec_t'(cmt_kind_i);
            rec_addr_o = cmt_addr_i;
            cnt_d      = '0;
         end
      end else if (!cap_i && hist_empty_i && armed_q) begin
         rec_vld_o  = 1'b1;
         rec_last_o = 1'b1;
         cnt_d      = '0;
         armed_d    = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         cnt_q   <= cnt_d;
         armed_q <= armed_d;
      end
   end

   AST_CNT_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q != '1); // R7
   AST_FINAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_vld_o && rec_last_o) |=> (cnt_q == '0 && !armed_q)); // R8
endmodule

// File: rtl/trc_fifo.sv
module trc_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] din_i,
   input  logic         rdy_i,
   output logic         vld_o,
   output logic [W-1:0] dout_o,
   output logic         err_o
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_q, wr_q, rd_nx, wr_nx;
   logic [CW-1:0] cnt_q;
   logic          err_q, full, pop, acc;

   assign full  = (cnt_q == CW'(DEPTH));
   assign vld_o = (cnt_q != '0);
   assign pop   = vld_o && rdy_i;
   assign acc   = push_i && (!full || pop);

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign rd_nx = rd_q + 1'b1;
         assign wr_nx = wr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign rd_nx = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
         assign wr_nx = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (acc) mem[wr_q] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
         err_q <= 1'b0;
      end else begin
         if (pop) rd_q <= rd_nx;
         if (acc) wr_q <= wr_nx;
         cnt_q <= cnt_q + CW'(acc) - CW'(pop);
         if (push_i && full && !pop) err_q <= 1'b1;
      end
   end

   assign dout_o = mem[rd_q];
   assign err_o  = err_q;

   AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH)); // R9
   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && !rdy_i) |=> (vld_o && $stable(dout_o))); // R9
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q); // R10
endmodule

// File: rtl/trc_compress.sv
module trc_compress
   import trc_pkg::*;
#(
   parameter int HIST_D = 3,
   parameter int FL_W   = 2,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 30,
   parameter int FIFO_D = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [2:0]        st_i,
   input  logic [FL_W-1:0]   fl_i,
   input  logic              show_vld_i,
   input  logic [ADDR_W-1:0] show_addr_i,
   output logic              rec_valid_o,
   input  logic              rec_ready_i,
   output logic [1:0]        rec_type_o,
   output logic [CNT_W-1:0]  rec_cnt_o,
   output logic [ADDR_W-1:0] rec_addr_o,
   output logic              rec_last_o,
   output logic              ovf_err_o
);
   localparam int REC_W = 2 + CNT_W + ADDR_W + 1;

   generate
      if (HIST_D < 1)  begin : g_bad_hist  $error("HIST_D must be at least 1");  end
      if (FL_W < 1)    begin : g_bad_fl    $error("FL_W must be at least 1");    end
      if (CNT_W < 2)   begin : g_bad_cnt   $error("CNT_W must be at least 2");   end
      if (ADDR_W < 1)  begin : g_bad_addr  $error("ADDR_W must be at least 1");  end
      if (FIFO_D < 2)  begin : g_bad_fifo  $error("FIFO_D must be at least 2");  end
   endgenerate

   logic              cmt_vld, hist_empty, rv, rl;
   kind_t             cmt_kind;
   logic [ADDR_W-1:0] cmt_addr, ra;
   rec_t              rt;
   logic [CNT_W-1:0]  rc;
   logic [REC_W-1:0]  fdin, fdout;

   trc_hist #(.HIST_D(HIST_D), .FL_W(FL_W), .ADDR_W(ADDR_W)) hist_i (
      .clk(clk), .rst_n(rst_n), .cap_i(cap_i), .st_i(st_i), .fl_i(fl_i),
      .show_vld_i(show_vld_i), .show_addr_i(show_addr_i),
      .cmt_vld_o(cmt_vld), .cmt_kind_o(cmt_kind), .cmt_addr_o(cmt_addr),
      .empty_o(hist_empty)
   );

   trc_runcnt #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) run_i (
      .clk(clk), .rst_n(rst_n), .cap_i(cap_i), .cmt_vld_i(cmt_vld),
      .cmt_kind_i(cmt_kind), .cmt_addr_i(cmt_addr), .hist_empty_i(hist_empty),
      .rec_vld_o(rv), .rec_type_o(rt), .rec_cnt_o(rc), .rec_addr_o(ra),
      .rec_last_o(rl)
   );

   assign fdin = {rt, rc, ra, rl};

   trc_fifo #(.DEPTH(FIFO_D), .W(REC_W)) fifo_i (
      .clk(clk), .rst_n(rst_n), .push_i(rv), .din_i(fdin),
      .rdy_i(rec_ready_i), .vld_o(rec_valid_o), .dout_o(fdout), .err_o(ovf_err_o)
   );

   assign {rec_type_o, rec_cnt_o, rec_addr_o, rec_last_o} = fdout;
endmodule

// File: tb/trc_compress_tb_top.sv
module trc_compress_tb_top;
   localparam int HD   = 3;
   localparam int FD   = 4;
   localparam int CMAX = 65535;

   typedef struct {int t; int c; int a; int l;} rec_s;
   typedef struct {int t; int a;} ent_s;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cap = 1'b0;
   logic [2:0]  st = '0;
   logic [1:0]  fl = '0;
   logic        shw = 1'b0;
   logic [29:0] sadr = '0;
   logic        rdy = 1'b1;
   logic        rec_valid, rec_last, ovf_err;
   logic [1:0]  rec_type;
   logic [15:0] rec_cnt;
   logic [29:0] rec_addr;

   int    nchk = 0, nerr = 0;
   bit    chk_en = 1'b0, done = 1'b0;
   string phase = "R1";

   ent_s pend[$];
   rec_s mf[$];
   rec_s dgot[$];
   int   mcnt = 0;
   bit   marmed = 1'b0, merr = 1'b0;

   always #5 clk = ~clk;

   trc_compress dut_i (
      .clk(clk), .rst_n(rst_n), .cap_i(cap), .st_i(st), .fl_i(fl),
      .show_vld_i(shw), .show_addr_i(sadr), .rec_valid_o(rec_valid),
      .rec_ready_i(rdy), .rec_type_o(rec_type), .rec_cnt_o(rec_cnt),
      .rec_addr_o(rec_addr), .rec_last_o(rec_last), .ovf_err_o(ovf_err)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // reference model, one step per clock
   always @(posedge clk) begin : model
      rec_s r;
      bit   have;
      bit   pop;
      ent_s e;
      if (!rst_n) begin
         pend.delete(); mf.delete(); mcnt = 0; marmed = 0; merr = 0;
      end else begin
         have = 0;
         pop  = (mf.size() > 0) && rdy;
         if (rec_valid && rdy)
            dgot.push_back('{int'(rec_type), int'(rec_cnt), int'(rec_addr), int'(rec_last)});
         if (cap) begin
            for (int k = int'(fl); k > 0 && pend.size() > 0; k--) void'(pend.pop_back());
            case (st)
               3'd1: pend.push_back('{3, 0});
               3'd2: pend.push_back('{0, 0});
               3'd3: pend.push_back('{1, 0});
               3'd4: pend.push_back('{2, 0});
               default: ;
            endcase
            if (pend.size() > HD) begin
               e = pend.pop_front();
               if (e.t == 3) begin
                  if (mcnt == CMAX - 1) begin r = '{3, CMAX, 0, 0}; have = 1; mcnt = 0; end
                  else mcnt++;
               end else begin
                  r = '{e.t, mcnt, e.a, 0}; have = 1; mcnt = 0;
               end
            end
            if (shw && pend.size() > 0 && pend[pend.size()-1].t == 2)
               pend[pend.size()-1].a = int'(sadr);
            marmed = 1;
         end else if (pend.size() > 0) begin
            e = pend.pop_front();
            if (e.t == 3) begin
               if (mcnt == CMAX - 1) begin r = '{3, CMAX, 0, 0}; have = 1; mcnt = 0; end
               else mcnt++;
            end else begin
               r = '{e.t, mcnt, e.a, 0}; have = 1; mcnt = 0;
            end
         end else if (marmed) begin
            r = '{3, mcnt, 0, 1}; have = 1; mcnt = 0; marmed = 0;
         end
         if (pop) void'(mf.pop_front());
         if (have) begin
            if (mf.size() < FD) mf.push_back(r);
            else merr = 1;
         end
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (chk_en) begin
         chk(phase, "rec_valid", int'(rec_valid), int'(mf.size() > 0));
         if (mf.size() > 0 && rec_valid) begin
            chk(phase, "rec_type", int'(rec_type), mf[0].t);
            chk(phase, "rec_cnt", int'(rec_cnt), mf[0].c);
            chk(phase, "rec_addr", int'(rec_addr), mf[0].a);
            chk(phase, "rec_last", int'(rec_last), mf[0].l);
         end
         chk(phase, "ovf_err", int'(ovf_err), int'(merr));
      end
   end

   task automatic cyc(input bit c, input int s, input int f, input bit sv, input int a);
      cap = c; st = 3'(s); fl = 2'(f); shw = sv; sadr = 30'(a);
      @(negedge clk);
   endtask

   task automatic close_win(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
   endtask

   task automatic exp_rec(input string req, input int t, input int c, input int a, input int l);
      rec_s r;
      if (dgot.size() == 0) begin
         chk(req, "record present", 0, 1);
      end else begin
         r = dgot.pop_front();
         chk(req, "got type", r.t, t);
         chk(req, "got count", r.c, c);
         chk(req, "got addr", r.a, a);
         chk(req, "got last", r.l, l);
      end
   endtask

   task automatic no_more(input string req);
      chk(req, "extra records", dgot.size(), 0);
      dgot.delete();
   endtask

   task automatic do_reset();
      chk_en = 0;
      rst_n = 0;
      cyc(0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0);
      rst_n = 1;
      cyc(0, 0, 0, 0, 0);
      dgot.delete();
      chk_en = 1;
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
         report();
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk_en = 1;

      // R1 reset state
      phase = "R1";
      chk("R1", "valid after reset", int'(rec_valid), 0);
      chk("R1", "err after reset", int'(ovf_err), 0);

      // R2 R3 R8: runs, direct branches, drain at close
      phase = "R3";
      for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 0);
      cyc(1, 2, 0, 0, 0);
      cyc(1, 1, 0, 0, 0);
      cyc(1, 6, 0, 0, 0);
      cyc(1, 1, 0, 0, 0);
      cyc(1, 3, 0, 0, 0);
      cyc(1, 0, 0, 0, 0);
      phase = "R8";
      close_win(8);
      exp_rec("R3", 0, 5, 0, 0);
      exp_rec("R2", 1, 2, 0, 0);
      exp_rec("R8", 3, 0, 0, 1);
      no_more("R8");

      // R4 indirect with and without show address
      phase = "R4";
      cyc(1, 4, 0, 1, 30'h1234567);
      cyc(1, 4, 0, 0, 0);
      cyc(1, 1, 0, 1, 30'h0ABCDEF);
      close_win(8);
      exp_rec("R4", 2, 0, 30'h1234567, 0);
      exp_rec("R4", 2, 0, 0, 0);
      exp_rec("R4", 3, 1, 0, 1);
      no_more("R4");

      // R5 cancellation
      phase = "R5";
      cyc(1, 1, 0, 0, 0);
      cyc(1, 1, 0, 0, 0);
      cyc(1, 2, 0, 0, 0);
      cyc(1, 0, 3, 0, 0);
      close_win(6);
      exp_rec("R5", 3, 0, 0, 1);
      no_more("R5");
      cyc(1, 1, 0, 0, 0);
      cyc(1, 2, 0, 0, 0);
      cyc(1, 1, 1, 0, 0);
      close_win(6);
      exp_rec("R5", 3, 2, 0, 1);
      no_more("R5");

      // R6 retire latency
      phase = "R6";
      cyc(1, 2, 0, 0, 0);
      cyc(1, 1, 0, 0, 0);
      cyc(1, 1, 0, 0, 0);
      chk("R6", "no record with 3 pending", int'(rec_valid), 0);
      cyc(1, 1, 0, 0, 0);
      chk("R6", "record after 4th entry", int'(rec_valid), 1);
      chk("R6", "record type", int'(rec_type), 0);
      close_win(8);
      dgot.delete();

      // R11 inputs ignored while closed
      phase = "R11";
      for (int i = 0; i < 6; i++) begin
         cyc(0, 2, 3, 1, 30'h3FFFFFFF);
         chk("R11", "no record while closed", int'(rec_valid), 0);
      end
      cyc(1, 1, 0, 0, 0);
      close_win(6);
      exp_rec("R11", 3, 1, 0, 1);
      no_more("R11");

      // R9 R10 stall, fill and drop
      phase = "R9";
      rdy = 0;
      cyc(1, 2, 0, 0, 0);
      cyc(1, 1, 0, 0, 0);
      cyc(1, 2, 0, 0, 0);
      cyc(1, 1, 0, 0, 0);
      cyc(1, 1, 0, 0, 0);
      cyc(1, 2, 0, 0, 0);
      for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0);
      cyc(1, 2, 0, 0, 0);
      for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0);
      chk("R9", "valid while stalled", int'(rec_valid), 1);
      chk("R9", "head count while stalled", int'(rec_cnt), 0);
      chk("R10", "no error yet", int'(ovf_err), 0);
      phase = "R10";
      cyc(1, 2, 0, 0, 0);
      cyc(1, 1, 0, 0, 0);
      cyc(1, 1, 0, 0, 0);
      cyc(1, 1, 0, 0, 0);
      chk("R10", "error after drop", int'(ovf_err), 1);
      rdy = 1;
      cyc(1, 0, 0, 0, 0);
      repeat (6) cyc(1, 0, 0, 0, 0);
      exp_rec("R9", 0, 0, 0, 0);
      exp_rec("R9", 0, 1, 0, 0);
      exp_rec("R9", 0, 2, 0, 0);
      exp_rec("R9", 0, 3, 0, 0);
      no_more("R10");
      close_win(8);
      dgot.delete();
      chk("R10", "error stays high", int'(ovf_err), 1);
      do_reset();
      chk("R10", "error cleared by reset", int'(ovf_err), 0);

      // R7 run-count overflow
      phase = "R7";
      for (int i = 0; i < CMAX + 3; i++) cyc(1, 1, 0, 0, 0);
      close_win(8);
      exp_rec("R7", 3, CMAX, 0, 0);
      exp_rec("R8", 3, 3, 0, 1);
      no_more("R7");

      done = 1;
      report();
   end
endmodule